// File: doc/BRIEF.md
# High-Speed Clock Lane Start/Stop Sequencer

This block steers the clock lane of a serial display transmitter between its low-power stop condition and continuous high-speed clocking. The link layer raises a single request line, timed to the byte clock, to ask for the high-speed clock and lowers it to release the clock. The sequencer answers with a fixed series of lane conditions. Each condition lasts a number of fast bit-rate clock cycles taken from two configuration words. The lane is then handed back to the stop condition.

The byte clock is not a separate input. It is a one-cycle tick, `byteTick`, raised in the last fast cycle of every group of four fast cycles, and it is brought out so the link layer can align its request changes. A start sequence moves the lane from stop to LP-01, then to LP-00, then to HS-0. It always ends on a byte boundary. The clock then toggles and `hsReady` is high. A stop sequence drives HS-0 for the trail time and then holds LP-11 for the exit time. After that the block signals when the fast clock may be gated off. Neither sequence can be cut short once it has started.

Top module: `hs_clk_lane_seq`

## Requirements
- R1: After reset the lane is in LP-11 (`lpPair` = 2'b11) with `hsEn`, `hsData` and `hsReady` low, and `stopState` and `shutdownOk` high.
- R2: A rise of `hsReq` placed just after a byte tick edge is acted on at the next byte tick edge. LP-01 (`lpPair` = 2'b01, `hsEn` low) therefore appears 4 fast cycles after the request changes.
- R3: LP-01 lasts 2 × `cfgA[20:16]` fast cycles. A zero field counts as 1, which gives 2 cycles.
- R4: LP-00 with `hsEn` low lasts `cfgA[31:24]` fast cycles. A zero field counts as 1.
- R5: HS-0 before the clock (`hsEn` high, `hsReady` low) lasts at least `cfgA[7:0]` fast cycles, with zero counting as 1. It is lengthened by the fewest cycles that make the whole start sequence a multiple of 4 fast cycles.
- R6: While the clock runs, `hsEn` and `hsReady` are high and `hsData` inverts on every fast cycle.
- R7: A fall of `hsReq` placed just after a byte tick edge is acted on at the next byte tick edge. `hsReady` drops there, and the clock stops there.
- R8: When the request is seen low at any byte tick during the start sequence, the start sequence still completes. The stop sequence then follows at once, and no clock cycle is emitted.
- R9: The stop sequence drives HS-0 for `cfgB[15:8]` fast cycles and then LP-11 for `cfgB[7:0]` fast cycles. A zero field counts as 1.
- R10: `shutdownOk` is low from the start of a start sequence. After the request fall is acted on, it returns high only once trail + exit + 8 fast cycles (two byte periods) have elapsed.
- R11: `stopState` is high exactly when the lane shows LP-11 with `hsEn` low. It is decoded from the lane state with no byte-clock retiming.
- R12: `reqConflict` is high in the same cycle whenever `hsReq` is high together with any of `escReq`, `ulpsReq` or `turnReq`, and is low otherwise.
- R13: Configuration words are captured when a start sequence begins. Changes made after that point, including changes to bits outside the named fields, have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock; all timing counts its cycles |
| rstN | input | 1 | Active-low asynchronous reset |
| hsReq | input | 1 | High-speed clock request from the link layer |
| escReq | input | 1 | Escape-mode request, used only for conflict detection |
| ulpsReq | input | 1 | Clock ultra-low-power request, used only for conflict detection |
| turnReq | input | 1 | Bus turnaround request, used only for conflict detection |
| cfgA | input | 32 | Start timing: [20:16] half LP-01 time, [31:24] LP-00 time, [7:0] HS-0 time |
| cfgB | input | 32 | Stop timing: [15:8] trail time, [7:0] exit time |
| byteTick | output | 1 | High in the last fast cycle of each byte period |
| lpPair | output | 2 | Low-power line pair {P,N} |
| hsEn | output | 1 | High-speed driver enable |
| hsData | output | 1 | High-speed clock bit |
| hsReady | output | 1 | High while the clock is being transmitted |
| stopState | output | 1 | Lane is in LP-11 |
| shutdownOk | output | 1 | Fast clock may be gated off |
| reqConflict | output | 1 | HS request overlaps another request |

## Verification
The assertions check several orderings on every cycle. `hsReady` is never high without `hsEn`. The clock bit inverts every cycle while ready. Ready rises and falls only on byte-tick boundaries. LP-01 is always entered from the stop condition. `shutdownOk` implies `stopState`. The phase lengths, the stretch of HS-0 to a byte boundary, the count of emitted clock cycles against the request timing, and the capture of configuration at start are visible only as whole scenarios. The bench measures them burst by burst against computed durations, under random field values, random hold times and configuration changes made mid-burst.

// File: rtl/hs_clk_pkg.sv
package hs_clk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LPX,
    ST_PREP,
    ST_ZERO,
    ST_HSCLK,
    ST_TRAIL,
    ST_EXIT,
    ST_POST
  } laneState_e;

  // strobes from the sequencing control to the timing datapath
  typedef struct packed {
    logic       latchCfg;   // capture both configuration words
    logic       loadTimer;  // reload the phase timer
    laneState_e loadSel;    // phase whose duration is loaded
    logic       hsClkOn;    // run the clock toggle
  } seqStrobe_t;

endpackage

// File: rtl/hs_clk_datapath.sv
module hs_clk_datapath
  import hs_clk_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int FIELD_W    = 8,
  parameter int TLPX_W     = 5,
  parameter int TLPX_LSB   = 16,
  parameter int PREP_LSB   = 24,
  parameter int ZERO_LSB   = 0,
  parameter int TRAIL_LSB  = 8,
  parameter int EXIT_LSB   = 0,
  parameter int BYTE_DIV   = 4,
  parameter int POST_BYTES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CFG_W-1:0] cfgA,
  input  logic [CFG_W-1:0] cfgB,
  output logic             timerZero,
  output logic             hsBit
);

  localparam int TIMER_W  = FIELD_W + 2;
  localparam int POST_LEN = BYTE_DIV * POST_BYTES;
  localparam logic [CFG_W-1:0] USED_A =
    (((CFG_W)'(1) << TLPX_W) - 1) << TLPX_LSB |
    (((CFG_W)'(1) << FIELD_W) - 1) << PREP_LSB |
    (((CFG_W)'(1) << FIELD_W) - 1) << ZERO_LSB;
  localparam logic [CFG_W-1:0] USED_B =
    (((CFG_W)'(1) << FIELD_W) - 1) << TRAIL_LSB |
    (((CFG_W)'(1) << FIELD_W) - 1) << EXIT_LSB;

  logic [CFG_W-1:0]   shadowA, shadowB;
  logic [CFG_W-1:0]   srcA, srcB;
  logic [TIMER_W-1:0] timer, loadVal;
  logic [FIELD_W-1:0] tlpxF, prepF, zeroF, trailF, exitF;
  logic               unusedCfgBits;
  logic               toggleQ;

  // a new start uses the words on the inputs, later phases the captured copy
  assign srcA = strobe.latchCfg ? cfgA : shadowA;
  assign srcB = strobe.latchCfg ? cfgB : shadowB;

  assign tlpxF  = FIELD_W'(srcA[TLPX_LSB +: TLPX_W]);
  assign prepF  = srcA[PREP_LSB  +: FIELD_W];
  assign zeroF  = srcA[ZERO_LSB  +: FIELD_W];
  assign trailF = srcB[TRAIL_LSB +: FIELD_W];
  assign exitF  = srcB[EXIT_LSB  +: FIELD_W];

  assign unusedCfgBits = ^{srcA & ~USED_A, srcB & ~USED_B};

  function automatic logic [TIMER_W-1:0] atLeastOne(input logic [FIELD_W-1:0] v);
    return (v == '0) ? TIMER_W'(1) : TIMER_W'(v);
  endfunction

  // timer holds (duration - 1) so the last cycle of a phase sees zero
  always_comb begin
    unique case (strobe.loadSel)
      ST_LPX:   loadVal = (atLeastOne(tlpxF) << 1) - TIMER_W'(1);
      ST_PREP:  loadVal = atLeastOne(prepF) - TIMER_W'(1);
      ST_ZERO:  loadVal = atLeastOne(zeroF) - TIMER_W'(1);
      ST_TRAIL: loadVal = atLeastOne(trailF) - TIMER_W'(1);
      ST_EXIT:  loadVal = atLeastOne(exitF) - TIMER_W'(1);
      default:  loadVal = TIMER_W'(POST_LEN - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowA <= '0;
      shadowB <= '0;
    end else if (strobe.latchCfg) begin
      shadowA <= cfgA;
      shadowB <= cfgB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (strobe.loadTimer) timer <= loadVal;
    else if (timer != '0)      timer <= timer - TIMER_W'(1);
  end

  assign timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               toggleQ <= 1'b0;
    else if (strobe.hsClkOn) toggleQ <= ~toggleQ;
    else                     toggleQ <= 1'b0;
  end

  assign hsBit = strobe.hsClkOn & toggleQ;

endmodule

// File: rtl/hs_clk_ctrl.sv
module hs_clk_ctrl
  import hs_clk_pkg::*;
#(
  parameter int BYTE_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsReq,
  input  logic       timerZero,
  output seqStrobe_t strobe,
  output laneState_e state,
  output logic       byteTick
);

  localparam int BYTE_W = (BYTE_DIV > 1) ? $clog2(BYTE_DIV) : 1;

  logic [BYTE_W-1:0] byteCnt;
  laneState_e        nextState;
  logic              dropSeen, inStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         byteCnt <= '0;
    else if (byteTick) byteCnt <= '0;
    else               byteCnt <= byteCnt + BYTE_W'(1);
  end

  assign byteTick = (byteCnt == BYTE_W'(BYTE_DIV - 1));
  assign inStart  = (state == ST_LPX) || (state == ST_PREP) || (state == ST_ZERO);

  always_comb begin
    nextState        = state;
    strobe.latchCfg  = 1'b0;
    strobe.loadTimer = 1'b0;
    strobe.loadSel   = ST_POST;
    strobe.hsClkOn   = (state == ST_HSCLK);
    unique case (state)
      ST_IDLE:
        if (byteTick && hsReq) begin
          nextState       = ST_LPX;
          strobe.latchCfg = 1'b1;
        end
      ST_LPX:   if (timerZero) nextState = ST_PREP;
      ST_PREP:  if (timerZero) nextState = ST_ZERO;
      ST_ZERO:
        if (timerZero && byteTick)
          nextState = (hsReq && !dropSeen) ? ST_HSCLK : ST_TRAIL;
      ST_HSCLK: if (byteTick && !hsReq) nextState = ST_TRAIL;
      ST_TRAIL: if (timerZero) nextState = ST_EXIT;
      ST_EXIT:  if (timerZero) nextState = ST_POST;
      default:  if (timerZero) nextState = ST_IDLE;
    endcase
    if (nextState != state && nextState != ST_HSCLK && nextState != ST_IDLE) begin
      strobe.loadTimer = 1'b1;
      strobe.loadSel   = nextState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // a low request seen at any tick of the start sequence forces a stop after it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            dropSeen <= 1'b0;
    else if (state == ST_IDLE)            dropSeen <= 1'b0;
    else if (inStart && byteTick && !hsReq) dropSeen <= 1'b1;
  end

endmodule

// File: rtl/hs_clk_lane_seq.sv
module hs_clk_lane_seq
  import hs_clk_pkg::*;
#(
  parameter int CFG_W      = 32,
  parameter int FIELD_W    = 8,
  parameter int TLPX_W     = 5,
  parameter int BYTE_DIV   = 4,
  parameter int POST_BYTES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsReq,
  input  logic             escReq,
  input  logic             ulpsReq,
  input  logic             turnReq,
  input  logic [CFG_W-1:0] cfgA,
  input  logic [CFG_W-1:0] cfgB,
  output logic             byteTick,
  output logic [1:0]       lpPair,
  output logic             hsEn,
  output logic             hsData,
  output logic             hsReady,
  output logic             stopState,
  output logic             shutdownOk,
  output logic             reqConflict
);

  seqStrobe_t strobe;
  laneState_e state;
  logic       timerZero;

  hs_clk_ctrl #(.BYTE_DIV(BYTE_DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hsReq    (hsReq),
    .timerZero(timerZero),
    .strobe   (strobe),
    .state    (state),
    .byteTick (byteTick)
  );

  hs_clk_datapath #(
    .CFG_W     (CFG_W),
    .FIELD_W   (FIELD_W),
    .TLPX_W    (TLPX_W),
    .BYTE_DIV  (BYTE_DIV),
    .POST_BYTES(POST_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgA     (cfgA),
    .cfgB     (cfgB),
    .timerZero(timerZero),
    .hsBit    (hsData)
  );

  always_comb begin
    unique case (state)
      ST_LPX:                       begin lpPair = 2'b01; hsEn = 1'b0; end
      ST_PREP:                      begin lpPair = 2'b00; hsEn = 1'b0; end
      ST_ZERO, ST_HSCLK, ST_TRAIL:  begin lpPair = 2'b00; hsEn = 1'b1; end
      default:                      begin lpPair = 2'b11; hsEn = 1'b0; end
    endcase
  end

  assign hsReady     = (state == ST_HSCLK);
  assign stopState   = (lpPair == 2'b11) && !hsEn;
  assign shutdownOk  = (state == ST_IDLE);
  assign reqConflict = hsReq && (escReq || ulpsReq || turnReq);

endmodule

// File: rtl/hs_clk_lane_seq_chk.sv
module hs_clk_lane_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hsReq,
  input logic       byteTick,
  input logic [1:0] lpPair,
  input logic       hsEn,
  input logic       hsData,
  input logic       hsReady,
  input logic       stopState,
  input logic       shutdownOk,
  input logic       reqConflict
);

  AST_READY_NEEDS_HS: assert property (@(posedge clk) disable iff (!rstN)
    hsReady |-> hsEn); // R6

  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    (hsReady && $past(hsReady)) |-> (hsData != $past(hsData))); // R6

  AST_READY_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsReady) |-> $past(byteTick)); // R5

  AST_READY_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsReady) |-> $past(byteTick)); // R7

  AST_LP01_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lpPair == 2'b01) |-> $past(stopState)); // R2

  AST_STOP_EXCLUDES_HS: assert property (@(posedge clk) disable iff (!rstN)
    hsEn |-> !stopState); // R11

  AST_SHUTDOWN_IN_STOP: assert property (@(posedge clk) disable iff (!rstN)
    shutdownOk |-> stopState); // R10

  AST_CONFLICT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqConflict |-> hsReq); // R12

endmodule

bind hs_clk_lane_seq hs_clk_lane_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hsReq      (hsReq),
  .byteTick   (byteTick),
  .lpPair     (lpPair),
  .hsEn       (hsEn),
  .hsData     (hsData),
  .hsReady    (hsReady),
  .stopState  (stopState),
  .shutdownOk (shutdownOk),
  .reqConflict(reqConflict)
);

// File: tb/hs_clk_lane_seq_bench.sv
module hs_clk_lane_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hsReq = 1'b0, escReq = 1'b0, ulpsReq = 1'b0, turnReq = 1'b0;
  logic [31:0] cfgA = '0, cfgB = '0;
  logic        byteTick, hsEn, hsData, hsReady, stopState, shutdownOk, reqConflict;
  logic [1:0]  lpPair;

  int checks = 0, fails = 0;
  int lat, c01, c00, cHsz, cClk, cStopLow, other, stopErr, togErr;

  always #10 clk = ~clk;

  hs_clk_lane_seq u_hs_clk_lane_seq (
    .clk(clk), .rstN(rstN), .hsReq(hsReq), .escReq(escReq), .ulpsReq(ulpsReq),
    .turnReq(turnReq), .cfgA(cfgA), .cfgB(cfgB), .byteTick(byteTick),
    .lpPair(lpPair), .hsEn(hsEn), .hsData(hsData), .hsReady(hsReady),
    .stopState(stopState), .shutdownOk(shutdownOk), .reqConflict(reqConflict)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int atLeast1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int expLpx(input logic [31:0] a);
    return 2 * atLeast1(int'(a[20:16]));
  endfunction

  function automatic int expZero(input logic [31:0] a);
    int z = atLeast1(int'(a[7:0]));
    while ((expLpx(a) + atLeast1(int'(a[31:24])) + z) % 4 != 0) z++;
    return z;
  endfunction

  function automatic int expSot(input logic [31:0] a);
    return expLpx(a) + atLeast1(int'(a[31:24])) + expZero(a);
  endfunction

  task automatic monitorBurst();
    bit started = 0;
    bit prevData = 0;
    lat = 0; c01 = 0; c00 = 0; cHsz = 0; cClk = 0; cStopLow = 0;
    other = 0; stopErr = 0; togErr = 0;
    while (1) begin
      @(negedge clk);
      if (stopState != ((lpPair == 2'b11) && !hsEn)) stopErr++;
      if (!started && lpPair == 2'b11 && !hsEn) begin
        lat++;
        if (lat > 64) break;
        continue;
      end
      started = 1;
      if (shutdownOk) break;
      if (hsEn && hsReady) begin
        if (cClk > 0 && hsData == prevData) togErr++;
        prevData = hsData;
        cClk++;
      end else if (hsReady) other++;
      else if (hsEn) begin
        cHsz++;
        if (hsData) togErr++;
      end else if (lpPair == 2'b01) c01++;
      else if (lpPair == 2'b00) c00++;
      else if (lpPair == 2'b11) cStopLow++;
      else other++;
    end
  endtask

  // k = number of byte tick edges after the rising request before it is dropped
  task automatic runBurst(input logic [31:0] a, input logic [31:0] b, input int k);
    int s, expClk, tr, ex;
    @(negedge clk);
    cfgA = a;
    cfgB = b;
    while (!byteTick) @(negedge clk);
    @(posedge clk);
    #1 hsReq = 1'b1;
    fork
      monitorBurst();
      begin
        repeat (k) begin
          @(negedge clk);
          while (!byteTick) @(negedge clk);
          @(posedge clk);
        end
        #1 hsReq = 1'b0;
        cfgA = $urandom;   // R13: must not disturb the burst in flight
        cfgB = $urandom;
      end
    join
    s      = expSot(a);
    expClk = (4 * k > s) ? 4 * k - s : 0;
    tr     = atLeast1(int'(b[15:8]));
    ex     = atLeast1(int'(b[7:0]));
    check(lat == 4, "R2 latency", lat, 4);
    check(c01 == expLpx(a), "R3 R13 LP-01 length", c01, expLpx(a));
    check(c00 == atLeast1(int'(a[31:24])), "R4 R13 LP-00 length", c00, atLeast1(int'(a[31:24])));
    check(cHsz == expZero(a) + tr, "R5 R9 HS-0 total", cHsz, expZero(a) + tr);
    if (expClk == 0) check(cClk == 0, "R8 no clock on early drop", cClk, 0);
    else             check(cClk == expClk, "R7 clock length", cClk, expClk);
    check(cStopLow == ex + 8, "R9 R10 exit plus shutdown delay", cStopLow, ex + 8);
    check(togErr == 0 && other == 0, "R6 clock toggle and encoding", togErr + other, 0);
    check(stopErr == 0, "R11 stop state decode", stopErr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(lpPair == 2'b11, "R1 lpPair", lpPair, 3);
    check(!hsEn && !hsData && !hsReady, "R1 hs outputs", {hsEn, hsData, hsReady}, 0);
    check(stopState && shutdownOk, "R1 stop and shutdown", {stopState, shutdownOk}, 3);

    // directed corners: all-zero fields, drop exactly at end of SoT, one tick later
    runBurst(32'h0000_0000, 32'h0000_0000, 1);
    runBurst(32'h0302_0005, 32'h0000_0402, 3);
    runBurst(32'h0302_0005, 32'h0000_0402, expSot(32'h0302_0005) / 4);
    runBurst(32'h0302_0005, 32'h0000_0402, expSot(32'h0302_0005) / 4 + 1);
    runBurst(32'hFFE1_FF06, 32'hFFFF_0101, 5);

    for (int i = 0; i < 30; i++) begin
      logic [31:0] a, b;
      int k;
      a = $urandom;
      b = $urandom;
      a[31:24] = 8'($urandom % 12);
      a[20:16] = 5'($urandom % 8);
      a[7:0]   = 8'($urandom % 16);
      b[15:8]  = 8'($urandom % 12);
      b[7:0]   = 8'($urandom % 12);
      k = 1 + int'($urandom % (expSot(a) / 4 + 3));
      runBurst(a, b, k);
    end

    // R12 conflict flag over every request combination
    cfgA = '0;
    cfgB = '0;
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      {hsReq, escReq, ulpsReq, turnReq} = 4'(m);
      #1 check(reqConflict == (m[3] && m[2:0] != 0), "R12 conflict flag",
               reqConflict, int'(m[3] && m[2:0] != 0));
    end
    @(negedge clk);
    {hsReq, escReq, ulpsReq, turnReq} = 4'b0;
    repeat (80) @(negedge clk);
    check(shutdownOk && stopState, "R10 idle after conflict test", shutdownOk, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule